// File: doc/BRIEF.md
# Multi-Mode Interval Timer Channel

This block is one down-counting timer channel. It produces a single waveform output in one of six gate-sensitive modes:
- a level that rises at terminal count
- a retriggerable one-shot started by the gate
- a divide-by-N rate pulse
- a square wave
- a strobe started by loading the count
- a strobe started by the gate

The count clock reaches the block as a one-cycle enable pulse (`tick`) in the system clock domain. The channel shows its current count on a port.

Software first writes a mode through `mode_wr`. It then writes an initial count through `load`. Byte sequencing, bus access and readback latching belong to the surrounding logic. The counter is one bit wider than the count port, so a loaded value of zero counts a full 2^CNT_W ticks.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset, `out` is 0, `count` is 0, mode 0 is selected and no count is running.
- R2: The counter moves down by one only on a cycle with `tick` high. A loaded value of zero stands for 2^CNT_W ticks, and `count` shows that value modulo 2^CNT_W.
- R3: Mode 0 (code 0), terminal-count level:
  - A load drives `out` low.
  - Each tick with `gate` high decrements the count. With `gate` low, counting pauses and `out` stays low.
  - After N counted ticks, `out` goes high and stays high until the next load or mode write.
- R4: Mode 1 (code 1), gate one-shot:
  - A load arms the channel and sets `out` high.
  - A rising edge of `gate` reloads N and drives `out` low. `out` returns high after N ticks, whatever the gate level.
  - A further rising edge retriggers, including during a pulse.
- R5: Mode 2 (code 2), rate generator:
  - While `gate` is high, the period is N ticks.
  - `out` is low for exactly one tick interval, the one in which the count equals 1, and high otherwise.
  - The count reloads automatically.
  - N=1 holds `out` high.
- R6: Mode 3 (code 3), square wave: the period is N ticks. `out` is high for ceil(N/2) ticks and low for floor(N/2) ticks, with the count reloading automatically.
- R7: Mode 4 (code 4), software strobe:
  - A load sets `out` high and starts counting on ticks while `gate` is high.
  - When the count reaches 0, `out` is low for one tick interval and then high.
  - Counting then stops, with no reload.
- R8: Mode 5 (code 5), hardware strobe:
  - A load arms the channel with `out` high.
  - A rising edge of `gate` starts or restarts the count. Counting then ignores the gate level.
  - The strobe behaves as in R7, after which the channel is armed again.
- R9: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R10: A mode write sets `out` on the next cycle: low for mode 0, high for every other mode. It stops any count and leaves `count` unchanged. A load in the same cycle is ignored.
- R11: In modes 2 and 3, `gate` low forces `out` high on the next cycle and freezes the count. A rising edge of `gate` restarts the period from N with `out` high.
- R12: Priority, from highest to lowest: mode write, load, gate rising edge, tick. A tick that coincides with a load or a restart is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-clock enable pulse |
| gate | input | 1 | Gate level, also used for edge triggers |
| mode_wr | input | 1 | Strobe that writes `mode_code` |
| mode_code | input | 3 | Mode selection, codes 0 to 7 |
| load | input | 1 | Strobe that writes `load_val` as the initial count |
| load_val | input | CNT_W | Initial count N (0 means 2^CNT_W) |
| out | output | 1 | Waveform output |
| count | output | CNT_W | Current count, low CNT_W bits |

## Verification
The bench builds the channel with CNT_W = 4. With that width, the zero-means-full-range count of 16 ticks and several complete periods of the periodic modes fit into short directed sequences. A 4-bit count also makes a long random stream of mode writes, loads, gate toggles and sparse ticks revisit odd and even periods and counts of 1 and 0 many times. Each cycle compares `out` and `count` against the behavioural model.

// File: rtl/tm_pkg.sv
package tm_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_RUN   = 2'd2,
        PH_STRB  = 2'd3
    } phase_e;
endpackage

// File: rtl/tm_gate_edge.sv
module tm_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/tm_mode_map.sv
module tm_mode_map (
    input  logic [2:0] code,
    output logic [2:0] eff,
    output logic       init_hi
);
    always_comb begin
        case (code)
            3'd6:    eff = 3'd2;
            3'd7:    eff = 3'd3;
            default: eff = code;
        endcase
        init_hi = (eff != 3'd0);
    end
endmodule

// File: rtl/tm_wave_level.sv
module tm_wave_level #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W:0] nxt,
    input  logic [CNT_W:0] rl,
    input  logic           square,
    output logic           lvl
);
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    always_comb begin
        if (square) lvl = (nxt > (rl >> 1));
        else        lvl = (nxt != ONE) || (rl == ONE);
    end
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             mode_wr,
    input  logic [2:0]       mode_code,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             out,
    output logic [CNT_W-1:0] count
);
    import tm_pkg::*;

    localparam int             FW   = CNT_W + 1;
    localparam logic [FW-1:0]  ONE  = FW'(1);
    localparam logic [FW-1:0]  ZERO = '0;
    localparam logic [FW-1:0]  FULL = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        logic [2:0]    mode;
        phase_e        ph;
        logic [FW-1:0] cnt;
        logic [FW-1:0] rl;
        logic          out;
    } chan_t;

    chan_t st_d, st_q;

    logic          g_rise;
    logic [2:0]    new_mode;
    logic          new_hi;
    logic [FW-1:0] full_val;
    logic [FW-1:0] per_nxt;
    logic          per_lvl;
    logic          periodic;

    tm_gate_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (g_rise)
    );

    tm_mode_map u_map (
        .code    (mode_code),
        .eff     (new_mode),
        .init_hi (new_hi)
    );

    assign full_val = (load_val == '0) ? FULL : {1'b0, load_val};
    assign per_nxt  = (st_q.cnt == ONE) ? st_q.rl : st_q.cnt - ONE;
    assign periodic = (st_q.mode == 3'd2) || (st_q.mode == 3'd3);

    tm_wave_level #(.CNT_W(CNT_W)) u_wave (
        .nxt    (per_nxt),
        .rl     (st_q.rl),
        .square (st_q.mode == 3'd3),
        .lvl    (per_lvl)
    );

    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d.mode = new_mode;
            st_d.out  = new_hi;
            st_d.ph   = PH_IDLE;
        end else if (load) begin
            st_d.rl = full_val;
            case (st_q.mode)
                3'd0: begin
                    st_d.cnt = full_val;
                    st_d.out = 1'b0;
                    st_d.ph  = PH_RUN;
                end
                3'd1, 3'd5: begin
                    st_d.out = 1'b1;
                    st_d.ph  = PH_ARMED;
                end
                default: begin
                    st_d.cnt = full_val;
                    st_d.out = 1'b1;
                    st_d.ph  = PH_RUN;
                end
            endcase
        end else if (g_rise && st_q.ph != PH_IDLE &&
                     (st_q.mode == 3'd1 || st_q.mode == 3'd5 || periodic)) begin
            st_d.cnt = st_q.rl;
            st_d.out = (st_q.mode != 3'd1);
            st_d.ph  = PH_RUN;
        end else begin
            if (tick) begin
                case (st_q.mode)
                    3'd0: if (st_q.ph == PH_RUN && gate) begin
                        st_d.cnt = st_q.cnt - ONE;
                        if (st_q.cnt == ONE) begin
                            st_d.out = 1'b1;
                            st_d.ph  = PH_IDLE;
                        end
                    end
                    3'd1: if (st_q.ph == PH_RUN) begin
                        st_d.cnt = st_q.cnt - ONE;
                        if (st_q.cnt == ONE) begin
                            st_d.out = 1'b1;
                            st_d.ph  = PH_ARMED;
                        end
                    end
                    3'd2, 3'd3: if (st_q.ph == PH_RUN && gate) begin
                        st_d.cnt = per_nxt;
                        st_d.out = per_lvl;
                    end
                    default: begin
                        if (st_q.ph == PH_RUN && (gate || st_q.mode == 3'd5)) begin
                            st_d.cnt = st_q.cnt - ONE;
                            if (st_q.cnt == ONE) begin
                                st_d.out = 1'b0;
                                st_d.ph  = PH_STRB;
                            end
                        end else if (st_q.ph == PH_STRB) begin
                            st_d.out = 1'b1;
                            st_d.ph  = (st_q.mode == 3'd5) ? PH_ARMED : PH_IDLE;
                        end
                    end
                endcase
            end
            if (periodic && st_q.ph == PH_RUN && !gate) st_d.out = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= 3'd0;
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= ZERO;
            st_q.rl   <= ZERO;
            st_q.out  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out   = st_q.out;
    assign count = st_q.cnt[CNT_W-1:0];

    // R10
    mode_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (out == ($past(mode_code) != 3'd0)));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !mode_wr && !g_rise) |=> $stable(count));

    // R3
    m0_load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !mode_wr && st_q.mode == 3'd0) |=> !out);

    // R5
    rate_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == 3'd2 && st_q.ph == PH_RUN && !out && tick &&
         !load && !mode_wr && !g_rise) |=> out);

    // R5
    rate_load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !mode_wr && st_q.mode == 3'd2) |=> (count == $past(load_val)));
endmodule

// File: tb/sim_interval_timer_chan.sv
module sim_interval_timer_chan;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         gate = 1'b0;
    logic         mode_wr = 1'b0;
    logic [2:0]   mode_code = 3'd0;
    logic         load = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         out;
    logic [W-1:0] count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int m_mode, m_rl, m_cnt, m_ph, m_out, m_gprev;

    always #10 clk = ~clk;

    interval_timer_chan #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
        .mode_wr(mode_wr), .mode_code(mode_code), .load(load),
        .load_val(load_val), .out(out), .count(count)
    );

    // behavioural reference: phases 0 idle, 1 armed, 2 running, 3 strobe
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_rl = 0; m_cnt = 0; m_ph = 0; m_out = 0; m_gprev = 0;
        end else begin
            int rise, n;
            rise = (gate && !m_gprev) ? 1 : 0;
            if (mode_wr) begin
                m_mode = (mode_code == 6) ? 2 : (mode_code == 7) ? 3 : int'(mode_code);
                m_out = (m_mode != 0) ? 1 : 0;
                m_ph = 0;
            end else if (load) begin
                n = (load_val == 0) ? (1 << W) : int'(load_val);
                m_rl = n;
                if (m_mode == 0) begin m_cnt = n; m_out = 0; m_ph = 2; end
                else if (m_mode == 1 || m_mode == 5) begin m_out = 1; m_ph = 1; end
                else begin m_cnt = n; m_out = 1; m_ph = 2; end
            end else if (rise == 1 && m_ph != 0 && m_mode != 0 && m_mode != 4) begin
                m_cnt = m_rl;
                m_out = (m_mode == 1) ? 0 : 1;
                m_ph = 2;
            end else begin
                if (tick) begin
                    if (m_mode == 0 && m_ph == 2 && gate) begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_out = 1; m_ph = 0; end
                    end else if (m_mode == 1 && m_ph == 2) begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_out = 1; m_ph = 1; end
                    end else if ((m_mode == 2 || m_mode == 3) && m_ph == 2 && gate) begin
                        m_cnt = (m_cnt == 1) ? m_rl : m_cnt - 1;
                        if (m_mode == 2) m_out = (m_cnt != 1 || m_rl == 1) ? 1 : 0;
                        else             m_out = (m_cnt > m_rl / 2) ? 1 : 0;
                    end else if (m_mode >= 4 && m_ph == 2 && (gate || m_mode == 5)) begin
                        m_cnt--;
                        if (m_cnt == 0) begin m_out = 0; m_ph = 3; end
                    end else if (m_mode >= 4 && m_ph == 3) begin
                        m_out = 1;
                        m_ph = (m_mode == 5) ? 1 : 0;
                    end
                end
                if ((m_mode == 2 || m_mode == 3) && m_ph == 2 && !gate) m_out = 1;
            end
            m_gprev = gate;
        end
    end

    task automatic compare(input string tag);
        logic [W-1:0] ec;
        ec = W'(m_cnt % (1 << W));
        n_chk++;
        if (out !== m_out[0] || count !== ec) begin
            n_bad++;
            $display("FAIL %s: out=%0b count=%0d expected out=%0b count=%0d",
                     tag, out, count, m_out[0], ec);
        end
    endtask

    task automatic apply(input logic t, input logic g, input logic ld, input int v,
                         input logic mw, input int mc, input string tag);
        tick = t; gate = g; load = ld; load_val = W'(v);
        mode_wr = mw; mode_code = 3'(mc);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic run(input int cycles, input logic g, input string tag);
        for (int i = 0; i < cycles; i++) apply(i % 2 == 0, g, 0, 0, 0, 0, tag);
    endtask

    task automatic setup(input int mc, input int v, input logic g, input string tag);
        apply(0, g, 0, 0, 1, mc, tag);
        apply(0, g, 1, v, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        // R3: count of 5, paused by gate midway
        setup(0, 5, 1, "R3");
        run(4, 1, "R3");
        run(6, 0, "R3");
        run(12, 1, "R3");
        // R2: zero load means full range
        apply(0, 1, 1, 0, 0, 0, "R2");
        run(36, 1, "R2");
        apply(0, 1, 0, 0, 0, 0, "R2");
        // R4: armed one-shot, retriggered mid pulse
        setup(1, 3, 0, "R4");
        run(4, 0, "R4");
        apply(0, 1, 0, 0, 0, 0, "R4");
        run(3, 1, "R4");
        apply(0, 0, 0, 0, 0, 0, "R4");
        apply(0, 1, 0, 0, 0, 0, "R4");
        run(10, 0, "R4");
        // R5: rate generator
        setup(2, 4, 1, "R5");
        run(20, 1, "R5");
        // R11: gate low holds high, rise restarts
        run(5, 0, "R11");
        run(10, 1, "R11");
        // R6: odd and even square waves
        setup(3, 5, 1, "R6");
        run(24, 1, "R6");
        apply(0, 1, 1, 6, 0, 0, "R6");
        run(26, 1, "R6");
        // R7: software strobe with a pause
        setup(4, 3, 1, "R7");
        run(3, 1, "R7");
        run(4, 0, "R7");
        run(10, 1, "R7");
        // R8: hardware strobe
        setup(5, 3, 0, "R8");
        run(6, 0, "R8");
        apply(0, 1, 0, 0, 0, 0, "R8");
        run(12, 0, "R8");
        // R9: alias codes
        setup(6, 3, 1, "R9");
        run(14, 1, "R9");
        setup(7, 3, 1, "R9");
        run(14, 1, "R9");
        // R10: mode write with simultaneous load, then counting stopped
        apply(1, 1, 1, 2, 1, 0, "R10");
        run(6, 1, "R10");
        // R12: tick coinciding with load and with gate edge
        apply(0, 1, 0, 0, 1, 2, "R12");
        apply(1, 1, 1, 3, 0, 0, "R12");
        apply(1, 0, 0, 0, 0, 0, "R12");
        apply(1, 1, 0, 0, 0, 0, "R12");
        run(8, 1, "R12");
        // random stream
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            apply(($urandom % 3) == 0, ($urandom % 8) != 0, r < 3, int'($urandom % 16),
                  r >= 98, int'($urandom % 8), "R12");
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule